// File: doc/BRIEF.md
# Card Detect Debounce Controller

This block watches the raw card-detect pin of a removable-card slot. It brings the pin into the clock domain and filters out contact bounce. It then presents one clean card-present status bit to the rest of the host controller. Each time the filtered status changes, the block raises a one-cycle interrupt request: one for insertion and one for removal.

The filtered status also protects the bus. When the card goes away while bus power and the card clock are both enabled, the block issues one-cycle strobes that force both settings off. While no card is reported, it holds the command and data drivers in high impedance, so that no line is driven into an empty slot. Detection runs whether or not the bus is powered. The software reset-all input reaches the block, but the block leaves its status and its filter untouched by it. Only the hardware reset restarts the filter.

All pins are plain level or pulse signals. There is no data stream, so the block has no valid/ready handshake.

Top module: `card_detect_ctrl`

## Requirements
- R1: `irq_insert` is high for exactly one cycle, in the first cycle in which `card_present` reads 1 after reading 0, and at no other time.
- R2: `irq_remove` is high for exactly one cycle, in the first cycle in which `card_present` reads 0 after reading 1, and at no other time.
- R3: `card_present` reads 0 while `rst_n` is low, while a new level is still being filtered, and while no card is present.
- R4: A change of `det_raw` reaches `card_present` HOLD_CYCLES+2 clock edges after it is applied: 2 edges of synchronizer and HOLD_CYCLES of filter. A level held for HOLD_CYCLES-1 cycles or fewer leaves `card_present` unchanged.
- R5: `sw_rst_all` has no effect on `card_present`, on the interrupt outputs or on the filter's progress.
- R6: `pwr_force_off` and `clk_force_off` pulse for one cycle together with `irq_remove` when `bus_pwr_on` and `clk_en_on` were both 1 at the clock edge that committed the removal. Otherwise they stay 0.
- R7: `line_oe_kill` is 1 in every cycle in which `card_present` is 0, including the very cycle of the fall, and is 0 while it is 1.
- R8: Detection and both interrupts operate identically with `bus_pwr_on` at 0 or 1.
- R9: Asserting `rst_n` low clears `card_present` at once and restarts the synchronizer and filter. After release, a card still present is reported after another HOLD_CYCLES+2 edges, with a fresh insertion pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous hardware reset, active low |
| sw_rst_all | input | 1 | Software reset-all; ignored by this block |
| det_raw | input | 1 | Raw card-detect pin, asynchronous, 1 = card seated |
| bus_pwr_on | input | 1 | Current bus power enable setting |
| clk_en_on | input | 1 | Current card clock enable setting |
| card_present | output | 1 | Filtered card-present status |
| irq_insert | output | 1 | One-cycle insertion interrupt request |
| irq_remove | output | 1 | One-cycle removal interrupt request |
| pwr_force_off | output | 1 | One-cycle strobe that clears bus power |
| clk_force_off | output | 1 | One-cycle strobe that clears the card clock enable |
| line_oe_kill | output | 1 | Forces command and data drivers to high impedance |

## Verification
The bound checker watches four things on every cycle:
- each interrupt request is a single-cycle pulse tied to an edge of the status;
- a force strobe never appears without a removal pulse;
- the force strobes appear whenever removal meets powered, clocked conditions;
- the drivers are released to high impedance at every removal.

Other behaviours only the bench scenarios can show, because they depend on the history of the raw pin:
- the exact filter latency;
- rejection of glitches one cycle short of the threshold;
- the indifference to the software reset-all;
- detection with power off;
- recovery after a hardware reset.

// File: rtl/cd_pkg.sv
package cd_pkg;
  typedef struct packed {
    logic rise;
    logic fall;
  } cd_edge_t;
endpackage

// File: rtl/cd_sync.sv
module cd_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_in,
  output logic d_out
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], d_in};
  end

  assign d_out = chain_q[STAGES-1];
endmodule

// File: rtl/cd_debounce.sv
module cd_debounce
  import cd_pkg::*;
#(
  parameter int HOLD = 16
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     s_in,
  output logic     level,
  output cd_edge_t commit
);
  localparam int CW = (HOLD > 1) ? $clog2(HOLD) : 1;
  localparam logic [CW-1:0] LIMIT = CW'(HOLD - 1);

  logic [CW-1:0] cnt_q;
  logic          level_q;
  logic          differ;
  logic          at_lim;

  always_comb begin
    differ      = (s_in != level_q);
    at_lim      = (cnt_q == LIMIT);
    commit.rise = differ && at_lim && s_in;
    commit.fall = differ && at_lim && !s_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      level_q <= 1'b0;
    end else if (!differ) begin
      cnt_q   <= '0;
    end else if (at_lim) begin
      cnt_q   <= '0;
      level_q <= s_in;
    end else begin
      cnt_q   <= cnt_q + 1'b1;
    end
  end

  assign level = level_q;
endmodule

// File: rtl/cd_event.sv
module cd_event
  import cd_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  cd_edge_t commit,
  input  logic     bus_pwr_on,
  input  logic     clk_en_on,
  output logic     ins_pulse,
  output logic     rem_pulse,
  output logic     force_off
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ins_pulse <= 1'b0;
      rem_pulse <= 1'b0;
      force_off <= 1'b0;
    end else begin
      ins_pulse <= commit.rise;
      rem_pulse <= commit.fall;
      force_off <= commit.fall && bus_pwr_on && clk_en_on;
    end
  end
endmodule

// File: rtl/card_detect_ctrl.sv
module card_detect_ctrl
  import cd_pkg::*;
#(
  parameter int HOLD_CYCLES = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sw_rst_all,
  input  logic det_raw,
  input  logic bus_pwr_on,
  input  logic clk_en_on,
  output logic card_present,
  output logic irq_insert,
  output logic irq_remove,
  output logic pwr_force_off,
  output logic clk_force_off,
  output logic line_oe_kill
);
  logic     det_sync;
  logic     level;
  cd_edge_t commit;
  logic     force_off;
  logic     unused_sw_rst;

  // Software reset-all deliberately does not reach the detect logic.
  assign unused_sw_rst = sw_rst_all;

  cd_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_in(det_raw), .d_out(det_sync)
  );

  cd_debounce #(.HOLD(HOLD_CYCLES)) u_deb (
    .clk(clk), .rst_n(rst_n), .s_in(det_sync), .level(level), .commit(commit)
  );

  cd_event u_evt (
    .clk(clk), .rst_n(rst_n), .commit(commit),
    .bus_pwr_on(bus_pwr_on), .clk_en_on(clk_en_on),
    .ins_pulse(irq_insert), .rem_pulse(irq_remove), .force_off(force_off)
  );

  assign card_present  = level;
  assign pwr_force_off = force_off;
  assign clk_force_off = force_off;
  assign line_oe_kill  = ~level;
endmodule

// File: rtl/cd_checker.sv
module cd_checker (
  input logic clk,
  input logic rst_n,
  input logic sw_rst_all,
  input logic det_raw,
  input logic bus_pwr_on,
  input logic clk_en_on,
  input logic card_present,
  input logic irq_insert,
  input logic irq_remove,
  input logic pwr_force_off,
  input logic clk_force_off,
  input logic line_oe_kill
);
  p_ins_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
    irq_insert |=> !irq_insert);
  p_ins_on_rise_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(card_present) |-> irq_insert);
  p_rem_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    irq_remove |=> !irq_remove);
  p_rem_on_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(card_present) |-> irq_remove);
  p_force_needs_rem_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_force_off || clk_force_off) |-> irq_remove);
  p_force_when_live_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_remove && $past(bus_pwr_on) && $past(clk_en_on)) |-> (pwr_force_off && clk_force_off));
  p_kill_on_rem_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_remove |-> line_oe_kill);
  p_no_irq_in_reset_r3: assert property (@(posedge clk)
    !rst_n |-> (!card_present && !irq_insert && !irq_remove));
endmodule

bind card_detect_ctrl cd_checker u_chk (.*);

// File: tb/tb_card_detect_ctrl.sv
module tb_card_detect_ctrl;
  localparam int H = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sw_rst_all = 1'b0;
  logic det_raw = 1'b0;
  logic bus_pwr_on = 1'b0;
  logic clk_en_on = 1'b0;
  logic card_present, irq_insert, irq_remove, pwr_force_off, clk_force_off, line_oe_kill;

  int checks = 0;
  int errors = 0;
  int n_ins = 0, n_rem = 0, n_frc = 0, pulse_err = 0;
  logic prev_ins = 1'b0, prev_rem = 1'b0;
  bit   done = 1'b0;

  always #4 clk = ~clk;

  card_detect_ctrl #(.HOLD_CYCLES(H), .SYNC_STAGES(2)) dut (
    .clk(clk), .rst_n(rst_n), .sw_rst_all(sw_rst_all), .det_raw(det_raw),
    .bus_pwr_on(bus_pwr_on), .clk_en_on(clk_en_on), .card_present(card_present),
    .irq_insert(irq_insert), .irq_remove(irq_remove), .pwr_force_off(pwr_force_off),
    .clk_force_off(clk_force_off), .line_oe_kill(line_oe_kill)
  );

  // Event monitor, sampled after the edge has settled.
  always @(posedge clk) begin
    #2;
    if (rst_n) begin
      if (irq_insert) n_ins++;
      if (irq_remove) n_rem++;
      if (pwr_force_off) n_frc++;
      if ((irq_insert && prev_ins) || (irq_remove && prev_rem)) pulse_err++;
      if (pwr_force_off != clk_force_off) pulse_err++;
      if (pwr_force_off && !irq_remove) pulse_err++;
    end
    prev_ins = irq_insert;
    prev_rem = irq_remove;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // {raw, pwr, clk, swr, n[7:0], status, ins[2:0], rem[2:0], frc[2:0]}
  localparam int NV = 12;
  localparam logic [21:0] VEC [NV] = '{
    {1'b1,1'b0,1'b0,1'b0, 8'd4, 1'b0, 3'd0, 3'd0, 3'd0}, // R4 glitch H-1 high
    {1'b0,1'b0,1'b0,1'b0, 8'd8, 1'b0, 3'd0, 3'd0, 3'd0},
    {1'b1,1'b0,1'b0,1'b0, 8'd6, 1'b0, 3'd0, 3'd0, 3'd0}, // R3 still filtering
    {1'b1,1'b0,1'b0,1'b0, 8'd1, 1'b1, 3'd1, 3'd0, 3'd0}, // R4 R8 insert unpowered
    {1'b0,1'b1,1'b1,1'b1, 8'd4, 1'b1, 3'd1, 3'd0, 3'd0}, // R5 glitch low with swr
    {1'b1,1'b1,1'b1,1'b0, 8'd8, 1'b1, 3'd1, 3'd0, 3'd0},
    {1'b0,1'b1,1'b1,1'b0, 8'd6, 1'b1, 3'd1, 3'd0, 3'd0},
    {1'b0,1'b1,1'b1,1'b0, 8'd1, 1'b0, 3'd1, 3'd1, 3'd1}, // R2 R6 R7 live removal
    {1'b1,1'b1,1'b0,1'b1, 8'd7, 1'b1, 3'd2, 3'd1, 3'd1}, // R5 insert under swr
    {1'b0,1'b1,1'b0,1'b0, 8'd7, 1'b0, 3'd2, 3'd2, 3'd1}, // R6 clock off: no force
    {1'b1,1'b0,1'b1,1'b0, 8'd7, 1'b1, 3'd3, 3'd2, 3'd1}, // R8
    {1'b0,1'b0,1'b1,1'b0, 8'd7, 1'b0, 3'd3, 3'd3, 3'd1}  // R8 removal unpowered
  };

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_run();
  end

  initial begin
    // R3 reset state
    repeat (3) @(negedge clk);
    chk("R3 status in reset", card_present, 0);
    chk("R7 kill in reset", line_oe_kill, 1);
    chk("R1 irq in reset", irq_insert | irq_remove, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      det_raw    = VEC[i][21];
      bus_pwr_on = VEC[i][20];
      clk_en_on  = VEC[i][19];
      sw_rst_all = VEC[i][18];
      repeat (int'(VEC[i][17:10])) @(negedge clk);
      chk("R3 R4 status", card_present, int'(VEC[i][9]));
      chk("R1 insert count", n_ins, int'(VEC[i][8:6]));
      chk("R2 remove count", n_rem, int'(VEC[i][5:3]));
      chk("R6 force count", n_frc, int'(VEC[i][2:0]));
      chk("R7 kill vs status", line_oe_kill, int'(!card_present));
    end

    // R9 hardware reset while inserted
    sw_rst_all = 1'b0;
    det_raw = 1'b1;
    repeat (H + 2) @(negedge clk);
    chk("R4 reinsert", card_present, 1);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R9 status cleared", card_present, 0);
    chk("R9 kill in reset", line_oe_kill, 1);
    rst_n = 1'b1;
    repeat (H + 1) @(negedge clk);
    chk("R9 refilter pending", card_present, 0);
    @(negedge clk);
    chk("R9 reported again", card_present, 1);
    chk("R9 fresh insert pulse", n_ins, 5);

    // R5 sw reset pulse while stable
    sw_rst_all = 1'b1;
    repeat (H + 4) @(negedge clk);
    chk("R5 status kept", card_present, 1);
    chk("R5 no extra irq", n_ins + n_rem, 8);
    sw_rst_all = 1'b0;

    chk("R1 R2 R6 pulse shape", pulse_err, 0);
    finish_run();
  end
endmodule